// File: doc/BRIEF.md
# Toggle-Handshake Single-Port RAM

This block is a synchronous single-port memory that sits beside a state-machine datapath. The controller does not pulse an enable. It holds a 32-bit request token, and the memory holds a 32-bit acknowledge token. Whenever the two tokens differ, the memory performs exactly one access. If the write-enable word is nonzero, the access is a write of the write data to the given address. If the write-enable word is zero, the access is a read of that address into the read-data register.

When the access completes, the memory copies the request token into its acknowledge token, and the pair is equal again. A request is therefore one-shot by construction. To ask for the next access, the controller changes its token once more, for example by incrementing it or flipping any bit. All updates, to the array, the acknowledge token and the read data, become visible at the clock edge that ends the cycle in which the tokens differed.

The reset is asynchronous and active-low. Its release is synchronised inside the block. The stored words themselves are not reset.

Top module: `toggle_sp_ram`

## Requirements
- R1: While reset is held, and after its release until the first access, the acknowledge token reads 0 and the read data reads 0.
- R2: While the request token equals the acknowledge token, nothing changes. The acknowledge token, the read data and every stored word keep their values, whatever the address, write data and write-enable inputs do.
- R3: When the tokens differ and the write-enable word is nonzero, the write data is stored at the address at the next rising clock edge.
- R4: When the tokens differ and the write-enable word is zero, the word stored at the address appears on the read data after the next rising clock edge.
- R5: At the edge that ends an access, the acknowledge token takes the value the request token had. Each change of the request token therefore causes exactly one access, including when accesses are requested on consecutive cycles.
- R6: A read leaves every stored word unchanged, and a write leaves the read data unchanged.
- R7: A write to an address at or beyond DEPTH changes no stored word. A read from such an address returns 0.
- R8: The token comparison covers all 32 bits, so tokens that differ only in bit 31 start an access.
- R9: Any nonzero write-enable word selects a write, including a word with only bit 31 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | TOKEN_W (32) | Request token from the controller |
| ack_o | output | TOKEN_W (32) | Acknowledge token; equals req_i when idle |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| we_i | input | DATA_W | Write-enable word; nonzero selects a write |
| rdata_o | output | DATA_W | Read-data register |

## Verification
On every cycle, the assertions check four things:
- after a pending request, the acknowledge token copies the request token;
- an idle cycle holds the acknowledge token and the read data;
- a write never disturbs the read data;
- an out-of-range read yields 0.

Array contents cannot be seen at the ports, so only the bench scenarios can show the following:
- that a write landed at the right word;
- that reads do not corrupt storage;
- that out-of-range writes alias nowhere;
- that idle cycles with active-looking inputs store nothing.

The bench finds each of these by sweeping the whole address space and reading everything back.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/tsr_rst_sync.sv
module tsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/tsr_handshake.sv
module tsr_handshake
  import tsr_pkg::*;
#(
  parameter int TOKEN_W = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TOKEN_W-1:0] req_i,
  input  logic [DATA_W-1:0]  we_i,
  output logic [TOKEN_W-1:0] ack_o,
  output acc_kind_e          kind_o
);
  logic [TOKEN_W-1:0] ack_q, ack_d;
  logic               pending;
  logic               ack_en;

  // Full-width comparison: any differing bit starts an access.
  assign pending = (req_i != ack_q);

  always_comb begin
    kind_o = ACC_IDLE;
    if (pending) kind_o = (we_i != '0) ? ACC_WRITE : ACC_READ;
    ack_en = pending;
    ack_d  = req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ack_q <= '0;
    else if (ack_en) ack_q <= ack_d;
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/tsr_store.sv
module tsr_store
  import tsr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [IDX_W-1:0]  idx;
  logic              in_range;
  logic              wr_en, rd_en;

  assign in_range = ({1'b0, addr_i} < LIMIT);
  assign idx      = IDX_W'(addr_i);
  assign wr_en    = (kind_i == ACC_WRITE) && in_range;
  assign rd_en    = (kind_i == ACC_READ);

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
      logic sel;
      assign sel = wr_en && (idx == IDX_W'(g));
      always_ff @(posedge clk_i) begin
        if (sel) mem_q[g] <= wdata_i;
      end
    end
  endgenerate

  always_comb begin
    rdata_d = '0;
    if (in_range) rdata_d = mem_q[idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/toggle_sp_ram.sv
module toggle_sp_ram
  import tsr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 6,
  parameter int DEPTH   = 16,
  parameter int TOKEN_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TOKEN_W-1:0] req_i,
  output logic [TOKEN_W-1:0] ack_o,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0]  we_i,
  output logic [DATA_W-1:0]  rdata_o
);
  logic      rst_n;
  acc_kind_e kind;

  tsr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  tsr_handshake #(.TOKEN_W(TOKEN_W), .DATA_W(DATA_W)) u_hs (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .req_i  (req_i),
    .we_i   (we_i),
    .ack_o  (ack_o),
    .kind_o (kind)
  );

  tsr_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .kind_i  (kind),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 6,
  parameter int DEPTH   = 16,
  parameter int TOKEN_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [TOKEN_W-1:0] req_i,
  input logic [TOKEN_W-1:0] ack_o,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  we_i,
  input logic [DATA_W-1:0]  rdata_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

  // R5: a pending request is acknowledged with the request value.
  p_ack_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != ack_o) |=> (ack_o == $past(req_i)));

  // R2: an idle cycle changes neither the token nor the read data.
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == ack_o) |=> ($stable(ack_o) && $stable(rdata_o)));

  // R6: a write leaves the read data alone.
  p_write_keeps_rdata_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i != ack_o) && (we_i != '0)) |=> $stable(rdata_o));

  // R7: an out-of-range read returns zero.
  p_oor_read_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i != ack_o) && (we_i == '0) && ({1'b0, addr_i} >= LIMIT)) |=> (rdata_o == '0));
endmodule

bind toggle_sp_ram tsr_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .TOKEN_W(TOKEN_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .ack_o   (ack_o),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .rdata_o (rdata_o)
);

// File: tb/toggle_sp_ram_bench.sv
module toggle_sp_ram_bench;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 16;
  localparam int NADDR  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic [31:0]       req;
  logic [31:0]       ack;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, we, rdata;

  int checks = 0;
  int failures = 0;
  logic [DATA_W-1:0] model [DEPTH];
  logic [DATA_W-1:0] last_rd;

  always #4 clk = ~clk;

  toggle_sp_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .TOKEN_W(32)) u_toggle_sp_ram (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .ack_o(ack),
    .addr_i(addr), .wdata_i(wdata), .we_i(we), .rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a, input int salt);
    return (32'(a) * 32'h0101_0101) ^ 32'hA500_0000 ^ 32'(salt);
  endfunction

  // One request: token changes by xor with flip; sampled one edge later.
  task automatic access(input int a, input logic [31:0] d, input logic [31:0] w,
                        input logic [31:0] flip);
    logic [31:0] new_req;
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; we = w;
    new_req = req ^ flip;
    req = new_req;
    @(posedge clk);
    #1;
    check("R5 ack", ack, new_req);
    if (w != 0) begin
      if (a < DEPTH) model[a] = d;
      check("R6 write keeps rdata", rdata, last_rd);
    end else begin
      last_rd = (a < DEPTH) ? model[a] : 32'h0;
      check((a < DEPTH) ? "R4 read" : "R7 oor read", rdata, last_rd);
    end
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; req = 0; addr = 0; wdata = 0; we = 0; last_rd = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset ack", ack, 0);
    check("R1 reset rdata", rdata, 0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 after release ack", ack, 0);
    check("R1 after release rdata", rdata, 0);

    // R3 / R7: write sweep over the whole address space, back to back.
    for (int a = 0; a < NADDR; a++) access(a, pat(a, 0), 32'h1, 32'h1);
    // R4 / R7: read sweep; R6: reads must not corrupt storage.
    for (int a = 0; a < NADDR; a++) access(a, 32'hDEAD_BEEF, 32'h0, 32'h2);
    for (int a = 0; a < NADDR; a++) access(a, 32'h0, 32'h0, 32'h4);

    // R9: only bit 31 of the write-enable set; R8: tokens differ only in bit 31.
    for (int a = 0; a < DEPTH; a++) access(a, pat(a, 77), 32'h8000_0000, 32'h8000_0000);
    for (int a = 0; a < DEPTH; a++) access(a, 32'h0, 32'h0, 32'h8000_0000);

    // R5: alternating write/read on consecutive cycles.
    for (int a = 0; a < DEPTH; a++) begin
      access(a, pat(a, 300), 32'hFFFF_FFFF, 32'h1);
      access(a, 32'h0, 32'h0, 32'h1);
    end

    // R2: idle cycles with write-looking inputs store nothing and hold outputs.
    access(5, 32'h0, 32'h0, 32'h10);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      addr = ADDR_W'(a); wdata = 32'h1234_5678; we = 32'hFFFF_FFFF;
      @(posedge clk); #1;
      check("R2 idle ack", ack, req);
      check("R2 idle rdata", rdata, last_rd);
    end
    for (int a = 0; a < DEPTH; a++) access(a, 32'h0, 32'h0, 32'h20);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule